// File: doc/BRIEF.md
# Clock Rate Lock Monitor

This block decides whether a clock coming out of a clock-management circuit really runs at the rate it should. A clock manager's own "locked" flag can stay high while its output runs at a harmonic, after its input clock stopped, or after the input changed between 33 and 66 MHz. This monitor does not use that flag. It counts edges of the monitored clock and compares them with a fixed number of cycles of a trusted crystal reference clock.

The monitored clock drives a free-running counter. The count is sent into the reference domain as Gray code through a two-flop synchroniser and converted back to binary there. The reference domain then runs a loop of three phases:

- It holds the clock manager in reset for a set number of cycles.
- It waits for the clock manager to settle.
- It measures windows of a fixed number of reference cycles.

Each window passes when the monitored count falls inside an expected value plus or minus a tolerance. Qualified lock asserts after several consecutive passing windows. Any single failing window drops lock and starts the reset loop again.

The rest of the chip stays in reset until lock has held for a set number of reference cycles. After that it is released and stays released.

Top module: `clk_rate_guard`

## Requirements
- R1: While `ref_rst_n` is low, `lock_ok` is 0, `cm_rst` is 1 and `sys_rst_n` is 0.
- R2: After `ref_rst_n` rises, the internal reset is released 2 reference cycles later. `cm_rst` then stays high for `CMRST_CYC` more cycles, so it is high for `CMRST_CYC`+2 samples in total. Every later `cm_rst` pulse lasts exactly `CMRST_CYC` reference cycles.
- R3: A window is `WIN_CYC` reference cycles long. It passes when the monitored-clock count over the window, taken after the Gray-code two-flop crossing, lies within `EXP_CNT`±`TOL` inclusive.
- R4: `lock_ok` rises at the end of the `PASS_NEED`-th consecutive passing window. With a correct clock this is sample 2+`CMRST_CYC`+`SETTLE_CYC`+`PASS_NEED`*`WIN_CYC` after reset release.
- R5: A single failing window clears `lock_ok` and raises `cm_rst` on the same reference edge. The first window after reset fails into a `cm_rst` pulse that is visible at sample 2+`CMRST_CYC`+`SETTLE_CYC`+`WIN_CYC`.
- R6: A monitored clock at half rate, stopped, or off by more than the tolerance never locks. In that case `cm_rst` pulses repeat every `CMRST_CYC`+`SETTLE_CYC`+`WIN_CYC` reference cycles and `sys_rst_n` stays 0.
- R7: `sys_rst_n` rises `SYSREL_CYC` reference cycles after `lock_ok` rises, provided lock holds throughout. Once high, it stays high until `ref_rst_n` falls.
- R8: If the monitored rate changes after lock, `lock_ok` drops within two windows. When the rate is restored, the block locks again.
- R9: `lock_ok` is never 1 in a cycle where `cm_rst` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| ref_clk | input | 1 | Trusted crystal reference clock |
| ref_rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| mon_clk | input | 1 | Clock under test, output of the clock manager |
| lock_ok | output | 1 | Qualified lock, measured from the frequency ratio |
| cm_rst | output | 1 | Active-high reset request to the clock manager |
| sys_rst_n | output | 1 | Active-low reset for downstream logic, reference domain |

## Verification
The checker watches four things on every reference cycle:

- The length of every clock-manager reset pulse.
- That lock never coexists with that reset.
- That lock only falls together with a new reset request.
- That the system reset is released only out of a held lock and is never taken back.

What the checker cannot see is whether the frequency decision is right. The bench shows that by running sweeps of monitored-clock periods around the tolerance edge, a half-rate clock, a stopped clock and a rate change at run time. It also checks the exact cycles at which lock, the reset pulses and the system release appear.

// File: rtl/rg_pkg.sv
package rg_pkg;
  typedef enum logic [1:0] {
    ST_CMRST   = 2'd0,
    ST_SETTLE  = 2'd1,
    ST_MEASURE = 2'd2
  } rg_state_e;
endpackage

// File: rtl/rg_rst_sync.sv
module rg_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic arst_n,
  output logic srst_n
);
  logic [STAGES-1:0] chain_q;

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) chain_q <= '0;
    else         chain_q <= {chain_q[STAGES-2:0], 1'b1};
  end

  assign srst_n = chain_q[STAGES-1];
endmodule

// File: rtl/rg_cnt_cross.sv
module rg_cnt_cross #(
  parameter int CW = 8
) (
  input  logic          mon_clk,
  input  logic          mon_rst_n,
  input  logic          ref_clk,
  input  logic          ref_rst_n,
  output logic [CW-1:0] ref_cnt
);
  logic [CW-1:0] bin_q, bin_d, gray_q, gray_d;
  logic [CW-1:0] s1_q, s2_q;

  // monitored domain: binary counter with registered Gray copy
  always_comb begin
    bin_d  = bin_q + 1'b1;
    gray_d = bin_d ^ (bin_d >> 1);
  end

  always_ff @(posedge mon_clk or negedge mon_rst_n) begin
    if (!mon_rst_n) begin
      bin_q  <= '0;
      gray_q <= '0;
    end else begin
      bin_q  <= bin_d;
      gray_q <= gray_d;
    end
  end

  // reference domain: two-flop synchroniser
  always_ff @(posedge ref_clk or negedge ref_rst_n) begin
    if (!ref_rst_n) begin
      s1_q <= '0;
      s2_q <= '0;
    end else begin
      s1_q <= gray_q;
      s2_q <= s1_q;
    end
  end

  // Gray back to binary
  always_comb begin
    ref_cnt[CW-1] = s2_q[CW-1];
    for (int i = CW - 2; i >= 0; i--) ref_cnt[i] = ref_cnt[i+1] ^ s2_q[i];
  end
endmodule

// File: rtl/rg_ctrl.sv
module rg_ctrl
  import rg_pkg::*;
#(
  parameter int CW        = 8,
  parameter int WIN_CYC   = 32,
  parameter int EXP_CNT   = 64,
  parameter int TOL       = 2,
  parameter int PASS_NEED = 3,
  parameter int CMRST_CYC = 4,
  parameter int SETTLE_CYC = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [CW-1:0] mon_cnt,
  output logic          lock,
  output logic          cm_rst
);
  localparam int T1   = (CMRST_CYC > SETTLE_CYC) ? CMRST_CYC : SETTLE_CYC;
  localparam int TMAX = (T1 > WIN_CYC) ? T1 : WIN_CYC;
  localparam int TW   = $clog2(TMAX + 1);
  localparam int PW   = $clog2(PASS_NEED + 1);
  localparam int LO   = EXP_CNT - TOL;
  localparam int HI   = EXP_CNT + TOL;

  rg_state_e     st_q, st_d;
  logic [TW-1:0] tmr_q, tmr_d;
  logic [CW-1:0] base_q, base_d, delta;
  logic [PW-1:0] pass_q, pass_d;
  logic          lock_q, lock_d, win_ok;

  always_comb begin
    st_d   = st_q;
    tmr_d  = tmr_q + 1'b1;
    base_d = base_q;
    pass_d = pass_q;
    lock_d = lock_q;
    delta  = mon_cnt - base_q;
    win_ok = (delta >= CW'(LO)) && (delta <= CW'(HI));
    unique case (st_q)
      ST_CMRST: if (tmr_q == TW'(CMRST_CYC - 1)) begin
        st_d  = ST_SETTLE;
        tmr_d = '0;
      end
      ST_SETTLE: if (tmr_q == TW'(SETTLE_CYC - 1)) begin
        st_d   = ST_MEASURE;
        tmr_d  = '0;
        base_d = mon_cnt;
      end
      ST_MEASURE: if (tmr_q == TW'(WIN_CYC - 1)) begin
        tmr_d  = '0;
        base_d = mon_cnt;
        if (win_ok) begin
          if (pass_q != PW'(PASS_NEED)) pass_d = pass_q + 1'b1;
          lock_d = lock_q | (pass_q >= PW'(PASS_NEED - 1));
        end else begin
          st_d   = ST_CMRST;
          pass_d = '0;
          lock_d = 1'b0;
        end
      end
      default: begin
        st_d  = ST_CMRST;
        tmr_d = '0;
      end
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= ST_CMRST;
      tmr_q  <= '0;
      base_q <= '0;
      pass_q <= '0;
      lock_q <= 1'b0;
    end else begin
      st_q   <= st_d;
      tmr_q  <= tmr_d;
      base_q <= base_d;
      pass_q <= pass_d;
      lock_q <= lock_d;
    end
  end

  assign lock   = lock_q;
  assign cm_rst = (st_q == ST_CMRST);
endmodule

// File: rtl/rg_release.sv
module rg_release #(
  parameter int SYSREL_CYC = 5
) (
  input  logic clk,
  input  logic rst_n,
  input  logic lock,
  output logic sys_rst_n
);
  localparam int RW = $clog2(SYSREL_CYC + 1);

  logic [RW-1:0] cnt_q, cnt_d;
  logic          rel_q, rel_d;

  always_comb begin
    cnt_d = cnt_q;
    rel_d = rel_q;
    if (!rel_q) begin
      if (!lock)                           cnt_d = '0;
      else if (cnt_q == RW'(SYSREL_CYC - 1)) rel_d = 1'b1;
      else                                 cnt_d = cnt_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      rel_q <= 1'b0;
    end else begin
      cnt_q <= cnt_d;
      rel_q <= rel_d;
    end
  end

  assign sys_rst_n = rel_q;
endmodule

// File: rtl/clk_rate_guard.sv
module clk_rate_guard #(
  parameter int CW         = 8,
  parameter int WIN_CYC    = 32,
  parameter int EXP_CNT    = 64,
  parameter int TOL        = 2,
  parameter int PASS_NEED  = 3,
  parameter int CMRST_CYC  = 4,
  parameter int SETTLE_CYC = 8,
  parameter int SYSREL_CYC = 5,
  parameter int SYNC_STG   = 2
) (
  input  logic ref_clk,
  input  logic ref_rst_n,
  input  logic mon_clk,
  output logic lock_ok,
  output logic cm_rst,
  output logic sys_rst_n
);
  logic          rst_ref_n, rst_mon_n;
  logic [CW-1:0] mon_cnt_ref;

  rg_rst_sync #(.STAGES(SYNC_STG)) u_rst_ref (
    .clk(ref_clk), .arst_n(ref_rst_n), .srst_n(rst_ref_n));

  rg_rst_sync #(.STAGES(SYNC_STG)) u_rst_mon (
    .clk(mon_clk), .arst_n(ref_rst_n), .srst_n(rst_mon_n));

  rg_cnt_cross #(.CW(CW)) u_cross (
    .mon_clk(mon_clk), .mon_rst_n(rst_mon_n),
    .ref_clk(ref_clk), .ref_rst_n(rst_ref_n),
    .ref_cnt(mon_cnt_ref));

  rg_ctrl #(
    .CW(CW), .WIN_CYC(WIN_CYC), .EXP_CNT(EXP_CNT), .TOL(TOL),
    .PASS_NEED(PASS_NEED), .CMRST_CYC(CMRST_CYC), .SETTLE_CYC(SETTLE_CYC)
  ) u_ctrl (
    .clk(ref_clk), .rst_n(rst_ref_n), .mon_cnt(mon_cnt_ref),
    .lock(lock_ok), .cm_rst(cm_rst));

  rg_release #(.SYSREL_CYC(SYSREL_CYC)) u_rel (
    .clk(ref_clk), .rst_n(rst_ref_n), .lock(lock_ok), .sys_rst_n(sys_rst_n));
endmodule

// File: rtl/clk_rate_guard_chk.sv
module clk_rate_guard_chk #(
  parameter int CMRST_CYC = 4
) (
  input logic clk,
  input logic rst_n,
  input logic lock_ok,
  input logic cm_rst,
  input logic sys_rst_n
);
  localparam int HW = $clog2(CMRST_CYC + 2) + 1;
  logic [HW-1:0] hi_len;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      hi_len <= '0;
    else if (cm_rst) hi_len <= hi_len + 1'b1;
    else             hi_len <= '0;
  end

  a_r2_cm_pulse_len: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(cm_rst) |-> (hi_len == HW'(CMRST_CYC)));

  a_r9_no_lock_in_cm_rst: assert property (@(posedge clk) disable iff (!rst_n)
    lock_ok |-> !cm_rst);

  a_r5_lock_falls_with_cm_rst: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(lock_ok) |-> cm_rst);

  a_r7_release_from_lock: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sys_rst_n) |-> $past(lock_ok));

  a_r7_release_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    sys_rst_n |=> sys_rst_n);
endmodule

bind clk_rate_guard clk_rate_guard_chk #(.CMRST_CYC(CMRST_CYC)) u_chk (
  .clk(ref_clk), .rst_n(rst_ref_n), .lock_ok(lock_ok),
  .cm_rst(cm_rst), .sys_rst_n(sys_rst_n));

// File: tb/tb_clk_rate_guard.sv
`timescale 1ps/1ps
module tb_clk_rate_guard;
  localparam int REF_PS = 20000;
  localparam int WIN = 32, EXPC = 64, TOLV = 2, PASSN = 3;
  localparam int CMR = 4, SETL = 8, SREL = 5, LAT = 2;
  localparam int T_FAIL1 = LAT + CMR + SETL + WIN;
  localparam int T_LOCK  = LAT + CMR + SETL + PASSN * WIN;
  localparam int LOOP    = CMR + SETL + WIN;
  localparam int WIN_PS  = WIN * REF_PS;

  logic ref_clk, ref_rst_n, mon_clk;
  logic lock_ok, cm_rst, sys_rst_n;
  int   mon_half = 5000;
  bit   mon_run  = 1'b1;
  int   checks = 0, errs = 0, k = 0;

  clk_rate_guard #(
    .WIN_CYC(WIN), .EXP_CNT(EXPC), .TOL(TOLV), .PASS_NEED(PASSN),
    .CMRST_CYC(CMR), .SETTLE_CYC(SETL), .SYSREL_CYC(SREL)
  ) dut (
    .ref_clk(ref_clk), .ref_rst_n(ref_rst_n), .mon_clk(mon_clk),
    .lock_ok(lock_ok), .cm_rst(cm_rst), .sys_rst_n(sys_rst_n));

  initial ref_clk = 1'b0;
  always #(REF_PS/2) ref_clk = ~ref_clk;

  initial mon_clk = 1'b0;
  always begin
    #(mon_half);
    if (mon_run) mon_clk = ~mon_clk;
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errs++;
      $display("FAIL %s actual=%0d expected=%0d (sample %0d)", req, act, exp, k);
    end
  endtask

  task automatic goto(input int t);
    while (k < t) begin
      @(negedge ref_clk);
      k++;
    end
  endtask

  task automatic start_run(input int half_ps, input bit run);
    ref_rst_n = 1'b0;
    mon_half  = half_ps;
    mon_run   = run;
    repeat (3) @(negedge ref_clk);
    ref_rst_n = 1'b1;
    k = 0;
  endtask

  initial begin
    repeat (150000) @(posedge ref_clk);
    errs++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errs);
    $finish;
  end

  initial begin
    int n;
    ref_rst_n = 1'b0;
    repeat (4) @(negedge ref_clk);
    // R1: reset state
    chk(lock_ok == 0, "R1 lock in reset", lock_ok, 0);
    chk(cm_rst == 1, "R1 cm_rst in reset", cm_rst, 1);
    chk(sys_rst_n == 0, "R1 sys_rst_n in reset", sys_rst_n, 0);

    // nominal clock: R2, R4, R7
    start_run(5000, 1'b1);
    n = 0;
    while (cm_rst && n < 100) begin
      n++;
      @(negedge ref_clk);
      k++;
    end
    chk(n == LAT + CMR, "R2 first cm_rst length", n, LAT + CMR);
    goto(T_LOCK - 1);
    chk(lock_ok == 0, "R4 lock before last window", lock_ok, 0);
    goto(T_LOCK);
    chk(lock_ok == 1, "R4 lock at third pass", lock_ok, 1);
    chk(cm_rst == 0, "R9 cm_rst low while locked", cm_rst, 0);
    goto(T_LOCK + SREL - 1);
    chk(sys_rst_n == 0, "R7 sys held", sys_rst_n, 0);
    goto(T_LOCK + SREL);
    chk(sys_rst_n == 1, "R7 sys released", sys_rst_n, 1);

    // R8: run-time drop to half rate, then back
    goto(T_LOCK + 20);
    mon_half = 10000;
    n = 0;
    while (lock_ok && n < 2 * WIN + 4) begin
      n++;
      @(negedge ref_clk);
      k++;
    end
    chk(lock_ok == 0, "R8 lock dropped after rate change", lock_ok, 0);
    chk(cm_rst == 1, "R5 cm_rst with lock drop", cm_rst, 1);
    chk(sys_rst_n == 1, "R7 sys stays released", sys_rst_n, 1);
    mon_half = 5000;
    n = 0;
    while (!lock_ok && n < 400) begin
      n++;
      @(negedge ref_clk);
      k++;
    end
    chk(lock_ok == 1, "R8 relock after restore", lock_ok, 1);
    chk(sys_rst_n == 1, "R7 sys still released", sys_rst_n, 1);

    // R5, R6: half rate never locks, pulses repeat
    start_run(10000, 1'b1);
    goto(T_FAIL1 - 1);
    chk(cm_rst == 0, "R5 settle/measure before fail", cm_rst, 0);
    goto(T_FAIL1);
    chk(cm_rst == 1, "R5 cm_rst after failing window", cm_rst, 1);
    goto(T_FAIL1 + LOOP - 1);
    chk(cm_rst == 0, "R6 gap before repeat pulse", cm_rst, 0);
    goto(T_FAIL1 + LOOP);
    chk(cm_rst == 1, "R6 repeated cm_rst pulse", cm_rst, 1);
    goto(300);
    chk(lock_ok == 0, "R6 half rate no lock", lock_ok, 0);
    chk(sys_rst_n == 0, "R6 half rate sys held", sys_rst_n, 0);

    // R6: stopped clock
    start_run(5000, 1'b0);
    goto(T_FAIL1);
    chk(cm_rst == 1, "R6 stopped clock fails window", cm_rst, 1);
    goto(300);
    chk(lock_ok == 0, "R6 stopped clock no lock", lock_ok, 0);
    chk(sys_rst_n == 0, "R6 stopped clock sys held", sys_rst_n, 0);

    // R3: sweep of monitored counts around the tolerance band
    for (int c = 56; c <= 72; c++) begin
      int d;
      d = (c > EXPC) ? c - EXPC : EXPC - c;
      if (d > TOLV - 1 && d < TOLV + 2) continue;
      start_run(WIN_PS / (2 * c), 1'b1);
      goto(T_LOCK + 1);
      if (d <= TOLV - 1)
        chk(lock_ok == 1, "R3 in-band count locks", lock_ok, 1);
      else
        chk(lock_ok == 0, "R3 out-of-band count rejected", lock_ok, 0);
    end

    $display("CHECKS %0d ERRORS %0d", checks, errs);
    $finish;
  end
endmodule